// File: doc/BRIEF.md
# Synchronous Burst SRAM Write Controller

This block is a cycle-level model of the control path of a synchronous burst SRAM with a 32-bit word split into four byte lanes. Each rising clock edge it samples two address strobes of different priority, an advance input, three chip enables and the write qualifiers. From these it decides whether the device is selected, loads or steps a 2-bit burst counter, and applies byte-masked writes to an internal word array. Reads are modelled only as far as needed to check writes: an access cycle that writes nothing captures the addressed word into a register, and that register is shown on the data output while the output enable is low.

A burst starts on either strobe. The processor strobe is honoured only while the device is selected. It outranks the controller strobe and blocks any write in its own cycle, and the following cycle accesses the loaded address. The controller strobe writes in its own cycle. A controller strobe that arrives while the device is deselected ends the burst. After either start, the counter steps through the low two address bits while the advance input is low and holds while it is high. The upper address bits stay fixed for the whole burst.

Top module: `burst_sram_wctl`

## Requirements
- R1: The device is selected only when `ce1N`=0, `ce2`=1 and `ce3N`=0. A controller strobe (`cStrobeN`=0) seen while deselected writes nothing and ends the burst, so the cycles after it write nothing until a selected strobe arrives.
- R2: With `gwN`=0 an enabled write cycle updates all four byte lanes, whatever `bweN` and `bwN` are.
- R3: With `gwN`=1 and `bweN`=0 each lane whose `bwN` bit is 0 is written. Bit 0 maps to data bits 7:0, bit 1 to 15:8, bit 2 to 23:16 and bit 3 to 31:24, so `bwN`=0 gives a full write. With `gwN`=1 and `bweN`=1 nothing is written.
- R4: A selected processor-strobe cycle (`pStrobeN`=0) writes nothing. The next non-strobe cycle accesses the loaded address whatever `advN` is.
- R5: In a non-strobe cycle of an active burst past its first access, `advN`=0 steps the low two address bits by one, wrapping from 3 to 0. The upper address bits never change during the burst.
- R6: In a non-strobe cycle with `advN`=1 the burst address holds, and a write lands again on the same word.
- R7: A selected controller-strobe cycle loads `addrIn` and writes that word in the same cycle. Issued in the middle of a burst, it restarts the burst from the new address.
- R8: When both strobes are low while the device is selected, the processor strobe wins. A processor strobe seen while deselected is ignored, and the burst in progress continues.
- R9: Any access that writes nothing loads the addressed word into the output register, visible the cycle after. `dataValid` equals the inverse of `oeN`, and `dataOut` reads 0 while `oeN`=1.
- R10: Reset clears the counter and the output register and leaves the device inactive. No write happens until a strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W | Word address loaded by a strobe |
| dataIn | input | 32 | Write data |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| pStrobeN | input | 1 | Processor address strobe, active low, higher priority |
| cStrobeN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| gwN | input | 1 | Global full-word write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | 4 | Byte-lane write strobes, active low, bit 0 is lane 7:0 |
| oeN | input | 1 | Output enable, active low |
| dataOut | output | 32 | Registered read word, 0 while disabled |
| dataValid | output | 1 | High while the output is driven |

## Verification
The assertions assume that every control input holds a known 0 or 1 at each rising edge, and that both strobes stay high while reset is asserted. Two of them compare the burst address with its value in the previous cycle. Those properties only make sense when that previous cycle lies after reset and carried no strobe, so their antecedents require both strobes to have been high in that cycle. The bench changes inputs only on falling clock edges and drives known values at all times. It holds the strobes high through every reset, and in its random phase it keeps addresses to a small window so that bursts overlap words that were written before.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] laneWe;
    logic             rdEn;
  } memCmd_t;
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              pStrobeN,
  input  logic              cStrobeN,
  input  logic              advN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  output memCmd_t           cmd,
  output logic [ADDR_W-1:0] accAddr
);
  localparam int CNT_W  = 2;
  localparam int BASE_W = ADDR_W - CNT_W;

  logic              selected;
  logic              loadP;
  logic              loadC;
  logic              loadSel;
  logic              contCyc;
  logic              writeOk;
  logic              activeQ;
  logic              firstHoldQ;
  logic [BASE_W-1:0] baseQ;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  cntNext;
  logic [LANES-1:0]  laneMask;

  // strobe decode and burst stepping
  always_comb begin
    selected = !ce1N && ce2 && !ce3N;
    loadP    = !pStrobeN && selected;
    loadC    = !cStrobeN && !loadP;
    loadSel  = loadP || (loadC && selected);
    contCyc  = activeQ && !loadP && !loadC;
    if (contCyc && !firstHoldQ && !advN) cntNext = cntQ + 1'b1;
    else                                 cntNext = cntQ;
    if (loadP || loadC) accAddr = addrIn;
    else                accAddr = {baseQ, cntNext};
  end

  // write qualification
  always_comb begin
    if (!gwN)       laneMask = '1;
    else if (!bweN) laneMask = ~bwN;
    else            laneMask = '0;
    writeOk    = (loadC && selected) || contCyc;
    cmd.laneWe = writeOk ? laneMask : '0;
    cmd.rdEn   = (loadSel || contCyc) && (cmd.laneWe == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ    <= 1'b0;
      firstHoldQ <= 1'b0;
      baseQ      <= '0;
      cntQ       <= '0;
    end else if (loadSel) begin
      activeQ    <= 1'b1;
      firstHoldQ <= loadP;
      baseQ      <= addrIn[ADDR_W-1:CNT_W];
      cntQ       <= addrIn[CNT_W-1:0];
    end else if (loadC) begin
      activeQ    <= 1'b0;
      firstHoldQ <= 1'b0;
    end else if (contCyc) begin
      cntQ       <= cntNext;
      firstHoldQ <= 1'b0;
    end
  end
endmodule

// File: rtl/bsram_dpath.sv
module bsram_dpath
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  memCmd_t           cmd,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] dIn,
  input  logic              oeN,
  output logic [DATA_W-1:0] dOut,
  output logic              dValid
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] rdWord;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [WORDS];
    logic [LANE_W-1:0] rdByteQ;

    always_ff @(posedge clk) begin
      if (cmd.laneWe[g]) laneMem[accAddr] <= dIn[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          rdByteQ <= '0;
      else if (cmd.rdEn)  rdByteQ <= laneMem[accAddr];
    end

    assign rdWord[g*LANE_W +: LANE_W] = rdByteQ;
  end

  assign dValid = !oeN;
  assign dOut   = dValid ? rdWord : '0;
endmodule

// File: rtl/burst_sram_wctl.sv
module burst_sram_wctl
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [31:0]       dataIn,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              pStrobeN,
  input  logic              cStrobeN,
  input  logic              advN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [3:0]        bwN,
  input  logic              oeN,
  output logic [31:0]       dataOut,
  output logic              dataValid
);
  memCmd_t           cmdW;
  logic [ADDR_W-1:0] accAddrW;

  bsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .pStrobeN(pStrobeN), .cStrobeN(cStrobeN), .advN(advN),
    .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .cmd(cmdW), .accAddr(accAddrW)
  );

  bsram_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmdW), .accAddr(accAddrW),
    .dIn(dataIn), .oeN(oeN), .dOut(dataOut), .dValid(dataValid)
  );
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              pStrobeN,
  input logic              cStrobeN,
  input logic              advN,
  input logic              gwN,
  input logic [3:0]        laneWe,
  input logic [ADDR_W-1:0] accAddr
);
  logic isSel;
  logic strobeSeenQ;
  logic strobeNow;

  assign isSel     = (ce1N == 1'b0) && (ce2 == 1'b1) && (ce3N == 1'b0);
  assign strobeNow = !pStrobeN || !cStrobeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          strobeSeenQ <= 1'b0;
    else if (strobeNow) strobeSeenQ <= 1'b1;
  end

  AST_NO_WRITE_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (laneWe != 4'b0) |-> (strobeSeenQ || strobeNow)); // R10

  AST_UNSEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!cStrobeN && !isSel) |-> (laneWe == 4'b0)); // R1

  AST_PSTROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!pStrobeN && isSel) |-> (laneWe == 4'b0)); // R4

  AST_GLOBAL_FULL_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (!gwN && (laneWe != 4'b0)) |-> (laneWe == 4'hF)); // R2

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (pStrobeN && cStrobeN && $past(pStrobeN) && $past(cStrobeN))
      |-> (accAddr[ADDR_W-1:2] == $past(accAddr[ADDR_W-1:2]))); // R5

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pStrobeN && cStrobeN && advN && $past(pStrobeN) && $past(cStrobeN))
      |-> $stable(accAddr)); // R6
endmodule

bind burst_sram_wctl bsram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
  .pStrobeN(pStrobeN), .cStrobeN(cStrobeN), .advN(advN), .gwN(gwN),
  .laneWe(cmdW.laneWe), .accAddr(accAddrW)
);

// File: tb/sim_burst_sram_wctl.sv
module sim_burst_sram_wctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [31:0]   dataIn = '0;
  logic          ce1N = 1'b0, ce2 = 1'b1, ce3N = 1'b0;
  logic          pStrobeN = 1'b1, cStrobeN = 1'b1, advN = 1'b1;
  logic          gwN = 1'b1, bweN = 1'b1, oeN = 1'b0;
  logic [3:0]    bwN = 4'hF;
  logic [31:0]   dataOut;
  logic          dataValid;

  int checks = 0;
  int errors = 0;
  string curReq = "R10";
  bit done = 1'b0;

  // reference model state
  logic [7:0] memM [int];
  bit    mActive = 0, mFirst = 0;
  int    mBase = 0, mCnt = 0;
  logic [31:0] expQ = '0;
  bit    expKnown = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram_wctl #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .pStrobeN(pStrobeN), .cStrobeN(cStrobeN), .advN(advN),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .oeN(oeN),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mActive = 0; mFirst = 0; mBase = 0; mCnt = 0;
    expQ = '0; expKnown = 1;
  endtask

  task automatic modelStep();
    bit sel, lp, lc, cont, acc;
    int nc, a;
    logic [3:0] mask;
    sel  = !ce1N && ce2 && !ce3N;
    lp   = !pStrobeN && sel;
    lc   = !cStrobeN && !lp;
    cont = mActive && !lp && !lc;
    nc   = (cont && !mFirst && !advN) ? (mCnt + 1) % 4 : mCnt;
    a    = (lp || lc) ? int'(addrIn) : mBase * 4 + nc;
    if (!gwN)       mask = 4'hF;
    else if (!bweN) mask = ~bwN;
    else            mask = 4'h0;
    if (!((lc && sel) || cont)) mask = 4'h0;
    acc = lp || (lc && sel) || cont;
    if (mask != 4'h0) begin
      for (int l = 0; l < 4; l++)
        if (mask[l]) memM[a*4+l] = dataIn[l*8 +: 8];
    end else if (acc) begin
      expKnown = 1;
      for (int l = 0; l < 4; l++) begin
        if (memM.exists(a*4+l)) expQ[l*8 +: 8] = memM[a*4+l];
        else expKnown = 0;
      end
    end
    if (lp || (lc && sel)) begin
      mBase = int'(addrIn) / 4; mCnt = int'(addrIn) % 4; mActive = 1; mFirst = lp;
    end else if (lc) begin
      mActive = 0; mFirst = 0;
    end else if (cont) begin
      mCnt = nc; mFirst = 0;
    end
  endtask

  // outputs compared against the model after every clock
  task automatic compareOut();
    chk(curReq, {31'b0, dataValid}, {31'b0, !oeN});
    if (oeN) chk(curReq, dataOut, 32'h0);
    else if (expKnown) chk(curReq, dataOut, expQ);
  endtask

  task automatic cyc(input int a, input bit pN, input bit cN, input bit adv,
                     input bit gw, input bit bwe, input logic [3:0] bw,
                     input logic [31:0] d);
    addrIn = a[AW-1:0]; pStrobeN = pN; cStrobeN = cN; advN = adv;
    gwN = gw; bweN = bwe; bwN = bw; dataIn = d;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareOut();
  endtask

  task automatic idle();
    cyc(0, 1, 1, 1, 1, 1, 4'hF, 32'h0);
  endtask

  task automatic wrWord(input int a, input logic [31:0] d);
    cyc(a, 1, 0, 1, 0, 1, 4'hF, d);
  endtask

  task automatic rdCheck(input string req, input int a, input logic [31:0] exp);
    curReq = req;
    cyc(a, 1, 0, 1, 1, 1, 4'hF, 32'h0);
    chk(req, dataOut, exp);
  endtask

  task automatic doReset();
    pStrobeN = 1; cStrobeN = 1; rstN = 0;
    @(posedge clk); @(posedge clk);
    modelReset();
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R10: reset state of the output
    curReq = "R10";
    chk("R10", dataOut, 32'h0);
    chk("R10", {31'b0, dataValid}, 32'h1);

    // R10: no write after reset until a strobe
    wrWord(0, 32'hA5A5_0001);
    doReset();
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, 0, 1, 4'hF, 32'hDEAD_BEEF);
    rdCheck("R10", 0, 32'hA5A5_0001);

    // R2: global write ignores byte controls
    curReq = "R2";
    cyc(16, 1, 0, 1, 0, 1, 4'hF, 32'h1122_3344);
    rdCheck("R2", 16, 32'h1122_3344);

    // R3: byte lanes A and C only
    curReq = "R3";
    cyc(16, 1, 0, 1, 1, 0, 4'b1010, 32'hAABB_CCDD);
    rdCheck("R3", 16, 32'h11BB_33DD);
    cyc(16, 1, 0, 1, 1, 1, 4'b0000, 32'hFFFF_FFFF);
    rdCheck("R3", 16, 32'h11BB_33DD);
    cyc(17, 1, 0, 1, 1, 0, 4'b0000, 32'h5555_6666);
    rdCheck("R3", 17, 32'h5555_6666);

    // R4: processor strobe cycle cannot write
    curReq = "R4";
    wrWord(48, 32'h3030_3030);
    cyc(48, 0, 1, 1, 0, 1, 4'hF, 32'h0000_0BAD);
    rdCheck("R4", 48, 32'h3030_3030);

    // R4, R5: burst from 33 walks 33,34,35 then wraps to 32
    curReq = "R5";
    cyc(33, 0, 1, 0, 0, 1, 4'hF, 32'h0000_0BAD);
    cyc(0, 1, 1, 0, 0, 1, 4'hF, 32'hD000_0000);
    cyc(0, 1, 1, 0, 0, 1, 4'hF, 32'hD000_0001);
    cyc(0, 1, 1, 0, 0, 1, 4'hF, 32'hD000_0002);
    cyc(0, 1, 1, 0, 0, 1, 4'hF, 32'hD000_0003);
    rdCheck("R4", 33, 32'hD000_0000);
    rdCheck("R5", 34, 32'hD000_0001);
    rdCheck("R5", 35, 32'hD000_0002);
    rdCheck("R5", 32, 32'hD000_0003);

    // R6: suspend rewrites the same word
    curReq = "R6";
    wrWord(64, 32'hE000_0000);
    cyc(0, 1, 1, 1, 0, 1, 4'hF, 32'hE000_0001);
    cyc(0, 1, 1, 0, 0, 1, 4'hF, 32'hE000_0002);
    rdCheck("R6", 64, 32'hE000_0001);
    rdCheck("R6", 65, 32'hE000_0002);

    // R7: controller strobe restarts mid burst
    curReq = "R7";
    wrWord(80, 32'hF000_0000);
    cyc(0, 1, 1, 0, 0, 1, 4'hF, 32'hF000_0001);
    wrWord(96, 32'hF000_0002);
    cyc(0, 1, 1, 0, 0, 1, 4'hF, 32'hF000_0003);
    rdCheck("R7", 80, 32'hF000_0000);
    rdCheck("R7", 81, 32'hF000_0001);
    rdCheck("R7", 96, 32'hF000_0002);
    rdCheck("R7", 97, 32'hF000_0003);

    // R1: each deselecting enable blocks writes and ends the burst
    curReq = "R1";
    wrWord(112, 32'h7070_7070);
    wrWord(113, 32'h7171_7171);
    for (int v = 0; v < 3; v++) begin
      ce1N = (v == 0); ce2 = (v != 1); ce3N = (v == 2);
      cyc(112, 1, 0, 1, 0, 1, 4'hF, 32'hBAD0_0000);
      ce1N = 0; ce2 = 1; ce3N = 0;
      cyc(0, 1, 1, 0, 0, 1, 4'hF, 32'hBAD0_0001);
      rdCheck("R1", 112, 32'h7070_7070);
      rdCheck("R1", 113, 32'h7171_7171);
    end

    // R8: both strobes selected, processor strobe wins
    curReq = "R8";
    wrWord(128, 32'h8080_8080);
    wrWord(129, 32'h8181_8181);
    cyc(128, 0, 0, 1, 0, 1, 4'hF, 32'hBAD0_0002);
    cyc(0, 1, 1, 0, 0, 1, 4'hF, 32'h8888_0000);
    rdCheck("R8", 128, 32'h8888_0000);
    rdCheck("R8", 129, 32'h8181_8181);
    // R8: deselected processor strobe is ignored
    wrWord(144, 32'h9000_0000);
    ce1N = 1;
    cyc(200, 0, 1, 0, 0, 1, 4'hF, 32'h9000_0001);
    ce1N = 0;
    rdCheck("R8", 145, 32'h9000_0001);
    rdCheck("R8", 144, 32'h9000_0000);

    // R9: output enable gates the port
    curReq = "R9";
    oeN = 1;
    rdCheck("R9", 145, 32'h0);
    chk("R9", {31'b0, dataValid}, 32'h0);
    oeN = 0;
    idle();
    chk("R9", dataOut, 32'h9000_0001);

    // mixed traffic, compared with the model every clock
    curReq = "R5";
    for (int i = 0; i < 3000; i++) begin
      bit sel;
      sel  = ($urandom_range(0, 99) < 85);
      ce1N = sel ? 1'b0 : 1'($urandom_range(0, 1));
      ce2  = sel ? 1'b1 : 1'($urandom_range(0, 1));
      ce3N = sel ? 1'b0 : 1'b1;
      oeN  = ($urandom_range(0, 99) < 20);
      cyc($urandom_range(0, 63), ($urandom_range(0, 99) >= 15),
          ($urandom_range(0, 99) >= 15), 1'($urandom_range(0, 1)),
          ($urandom_range(0, 99) >= 30), 1'($urandom_range(0, 1)),
          4'($urandom_range(0, 15)), $urandom());
    end
    ce1N = 0; ce2 = 1; ce3N = 0; oeN = 0;
    idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule